// File: doc/BRIEF.md
# Genlock Subcarrier Serial Transmitter

This block runs a colour subcarrier phase accumulator and, once per scan line, shifts that accumulator's frequency control word out on a single serial pin. A slave device on the same pin decodes the word and steers its own subcarrier oscillator, so the two stay in colour lock. Each line's frame begins on a line-start strobe. The frame holds a start bit, the frequency word most significant bit first, a fixed gap, and one phase-reset slot.

Software may ask for a phase reset by writing a request strobe. The request waits for the start of the next line. On that line the reset slot is driven low (active low). While the slot is on the wire, the local accumulator is forced to zero. The request then clears itself. The bit rate is one bit per clock in fast mode, or one bit every four clocks in slow mode.

Top module: `genlock_tx`

## Requirements
- R1: While reset is asserted, `ser_out` is 0 and `dco_phase` is 0.
- R2: Outside a frame the serial line idles at 0.
- R3: A frame starts on the clock edge that samples `line_start` high. Slot 0 follows at once and carries a 1 (start bit).
- R4: Slots 1 to 23 carry the frequency word sampled at the frame's start edge, bit 22 first and bit 0 in slot 23. Later changes of `freq_word` do not alter the frame.
- R5: With `slow_mode` = 0 at the start edge, each slot lasts one clock.
- R6: With `slow_mode` = 1 at the start edge, each slot lasts four clocks. Changes of `slow_mode` during a frame have no effect on that frame.
- R7: Slots 24 to 29 are 0. Slot 30, seven bit periods after the last word bit, is the phase-reset slot. The frame ends after slot 30.
- R8: If no reset was pending at the frame's start edge, slot 30 is 1.
- R9: A `rst_req_wr` pulse marks a reset pending. A request pending at a frame's start edge makes slot 30 of that frame 0. A request written after the start edge waits for the next frame.
- R10: For every clock spent in an active (0) reset slot, `dco_phase` is 0 on the following cycle.
- R11: A request clears itself once its reset slot has been sent. The next frame's slot 30 is 1 unless there is a new write.
- R12: On every other clock, `dco_phase` advances by `freq_word` modulo 2^23.
- R13: A `line_start` during a frame abandons that frame and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-clock strobe at the start of a scan line |
| freq_word | input | 23 | Subcarrier frequency control word |
| slow_mode | input | 1 | 1: one bit per four clocks, 0: one bit per clock |
| rst_req_wr | input | 1 | Write strobe requesting a phase reset |
| ser_out | output | 1 | Serial frequency/reset line |
| dco_phase | output | 23 | Subcarrier phase accumulator |

## Verification
The bench aims at request timing. A request written in the middle of a frame must not reach that frame's reset slot. It must reach the next frame's slot and then vanish, and a design that captured requests live or never cleared them would show a 0 in the wrong frame. Slow-mode frames, with `slow_mode` toggled mid-frame, expose a divider that reads the live pin or stretches the wrong slot. Restarts in mid-frame, including restarts during a slow reset slot, expose stale slot counters. In every cycle the accumulator is compared with a model, which shows a clear that lasts too long or a missing wrap.

// File: rtl/genlock_pkg.sv
package genlock_pkg;
    localparam int unsigned GL_WORD_W = 23;
    localparam int unsigned GL_GAP    = 7;
    localparam int unsigned GL_DIV    = 4;
endpackage

// File: rtl/gl_slot_timer.sv
module gl_slot_timer #(
    parameter int unsigned LAST   = 30,
    parameter int unsigned DIV    = 4,
    localparam int unsigned SLOT_W = $clog2(LAST + 1),
    localparam int unsigned SUB_W  = $clog2(DIV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              slow_in,
    output logic              active,
    output logic [SLOT_W-1:0] slot
);
    typedef struct packed {
        logic              active;
        logic              slow;
        logic [SLOT_W-1:0] slot;
        logic [SUB_W-1:0]  sub;
    } tmr_t;

    tmr_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d = st_q;
        tick = !st_q.slow || (st_q.sub == SUB_W'(DIV - 1));
        if (line_start) begin
            st_d.active = 1'b1;
            st_d.slow   = slow_in;
            st_d.slot   = '0;
            st_d.sub    = '0;
        end else if (st_q.active) begin
            st_d.sub = tick ? '0 : st_q.sub + SUB_W'(1);
            if (tick) begin
                if (st_q.slot == SLOT_W'(LAST)) begin
                    st_d.active = 1'b0;
                    st_d.slot   = '0;
                end else begin
                    st_d.slot = st_q.slot + SLOT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign slot   = st_q.slot;

    assert_fast_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && !st_q.slow && st_q.slot != SLOT_W'(LAST) && !line_start
        |=> st_q.slot == $past(st_q.slot) + SLOT_W'(1));

    assert_slow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && st_q.slow && st_q.sub != SUB_W'(DIV - 1) && !line_start
        |=> $stable(st_q.slot));

    assert_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> st_q.active && st_q.slot == '0);
endmodule

// File: rtl/gl_serial_mux.sv
module gl_serial_mux #(
    parameter int unsigned WORD_W = 23,
    parameter int unsigned GAP    = 7,
    localparam int unsigned LAST   = WORD_W + GAP,
    localparam int unsigned SLOT_W = $clog2(LAST + 1)
) (
    input  logic              active,
    input  logic [SLOT_W-1:0] slot,
    input  logic [WORD_W-1:0] word,
    input  logic              armed,
    output logic              bit_o,
    output logic              rst_slot_o
);
    logic [WORD_W-1:0] shifted;

    always_comb begin
        shifted    = word << (slot - SLOT_W'(1));
        bit_o      = 1'b0;
        rst_slot_o = 1'b0;
        if (active) begin
            if (slot == '0) begin
                bit_o = 1'b1;
            end else if (slot <= SLOT_W'(WORD_W)) begin
                bit_o = shifted[WORD_W-1];
            end else if (slot == SLOT_W'(LAST)) begin
                bit_o      = !armed;
                rst_slot_o = armed;
            end
        end
    end
endmodule

// File: rtl/gl_dco.sv
module gl_dco #(
    parameter int unsigned WORD_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] freq,
    input  logic              clr,
    output logic [WORD_W-1:0] phase
);
    logic [WORD_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = clr ? '0 : phase_q + freq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/genlock_tx.sv
module genlock_tx
    import genlock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_start,
    input  logic [GL_WORD_W-1:0] freq_word,
    input  logic                 slow_mode,
    input  logic                 rst_req_wr,
    output logic                 ser_out,
    output logic [GL_WORD_W-1:0] dco_phase
);
    localparam int unsigned LAST   = GL_WORD_W + GL_GAP;
    localparam int unsigned SLOT_W = $clog2(LAST + 1);

    typedef struct packed {
        logic [GL_WORD_W-1:0] word;
        logic                 armed;
        logic                 pend;
    } tx_t;

    tx_t st_d, st_q;
    logic              tmr_active;
    logic [SLOT_W-1:0] tmr_slot;
    logic              rst_slot;

    gl_slot_timer #(.LAST(LAST), .DIV(GL_DIV)) timer_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .slow_in(slow_mode), .active(tmr_active), .slot(tmr_slot)
    );

    gl_serial_mux #(.WORD_W(GL_WORD_W), .GAP(GL_GAP)) mux_i (
        .active(tmr_active), .slot(tmr_slot), .word(st_q.word),
        .armed(st_q.armed), .bit_o(ser_out), .rst_slot_o(rst_slot)
    );

    gl_dco #(.WORD_W(GL_WORD_W)) dco_i (
        .clk(clk), .rst_n(rst_n), .freq(freq_word),
        .clr(rst_slot), .phase(dco_phase)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend && !rst_slot) || rst_req_wr;
        if (line_start) begin
            st_d.word  = freq_word;
            st_d.armed = st_q.pend && !rst_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_start_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> ser_out);

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_active |-> !ser_out);

    assert_phase_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_slot |=> dco_phase == '0);

    assert_req_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_slot && !rst_req_wr |=> !st_q.pend);
endmodule

// File: tb/genlock_tx_tb.sv
module genlock_tx_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  W = 23;
    localparam int  WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_start = 1'b0;
    logic [W-1:0] freq_word = '0;
    logic         slow_mode = 1'b0;
    logic         rst_req_wr = 1'b0;
    logic         ser_out;
    logic [W-1:0] dco_phase;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit         m_act, m_slow, m_armed, m_pend;
    int         m_cnt;
    logic [W-1:0] m_word, m_phase;

    genlock_tx dut_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .freq_word(freq_word),
        .slow_mode(slow_mode), .rst_req_wr(rst_req_wr),
        .ser_out(ser_out), .dco_phase(dco_phase)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int m_slot();
        return m_slow ? m_cnt / 4 : m_cnt;
    endfunction

    function automatic bit exp_ser();
        int s = m_slot();
        if (!m_act) return 1'b0;
        if (s == 0) return 1'b1;
        if (s <= 23) return m_word[23 - s];
        if (s < 30) return 1'b0;
        return !m_armed;
    endfunction

    function automatic string ser_tag();
        int s = m_slot();
        string rate = m_slow ? "R6" : "R5";
        if (!m_act) return "R2";
        if (s == 0) return {"R3/R13 ", rate};
        if (s <= 23) return {"R4 ", rate};
        if (s < 30) return {"R7 ", rate};
        return m_armed ? "R9 R7" : "R8 R11";
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(input bit ls, input bit wr, input bit slow);
        bit cur_rst;
        int ns;
        logic [W-1:0] f;
        f = W'($urandom);
        line_start = ls; rst_req_wr = wr; slow_mode = slow; freq_word = f;
        @(posedge clk);
        cur_rst = m_act && m_slot() == 30 && m_armed;
        m_phase = cur_rst ? '0 : m_phase + f;
        if (ls) begin
            m_armed = m_pend && !cur_rst;
            m_act = 1; m_cnt = 0; m_slow = slow; m_word = f;
        end else if (m_act) begin
            m_cnt++;
            ns = m_slot();
            if (ns > 30) begin m_act = 0; m_cnt = 0; end
        end
        m_pend = (m_pend && !cur_rst) || wr;
        @(negedge clk);
        check(ser_tag(), ser_out, exp_ser());
        check("R12 R10 phase", dco_phase, m_phase);
    endtask

    task automatic run_frame(input bit slow, input int len, input int wr_at);
        for (int i = 0; i < len; i++) cycle(i == 0, i == wr_at, $urandom % 2);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        m_act = 0; m_slow = 0; m_armed = 0; m_pend = 0; m_cnt = 0;
        m_word = '0; m_phase = '0;
        repeat (3) @(negedge clk);
        check("R1 ser in reset", ser_out, 0);
        check("R1 phase in reset", dco_phase, 0);
        rst_n = 1'b1;
        // fast frame, no request, then request written mid-frame
        for (int i = 0; i < 40; i++) cycle(i == 0, i == 10, 0);
        // next line carries the reset; then it must be gone
        for (int i = 0; i < 40; i++) cycle(i == 0, 0, 0);
        for (int i = 0; i < 40; i++) cycle(i == 0, 0, 0);
        // slow frame with mode toggled mid-frame and a request
        for (int i = 0; i < 130; i++) cycle(i == 0, i == 3, i < 1 ? 1 : i % 2);
        for (int i = 0; i < 130; i++) cycle(i == 0, 0, i == 0);
        // restart inside a slow reset slot
        for (int i = 0; i < 130; i++) cycle(i == 0 || i == 121, i == 5, i == 0 || i == 121);
        for (int i = 0; i < 130; i++) cycle(i == 0, 0, 0);
        // random lines
        for (int n = 0; n < 120; n++) begin
            int len = 15 + $urandom % 150;
            for (int i = 0; i < len; i++)
                cycle(i == 0, ($urandom % 60) == 0, (i == 0) ? ($urandom % 2) : ($urandom % 2));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule